// File: doc/BRIEF.md
# Stereo Audio Serial Port Master

This block drives a stereo audio codec as the clock master of an I2S-style serial link. A single system clock feeds it, and that clock must be twice the codec master clock. From it the block makes the master clock, a frame clock that runs at the sample rate, and a bit clock. Two parallel transmit words, one per channel, are sent out serially. Serial receive data is collected back into one parallel register per channel.

Four parameters set the timing: the master clock frequency, the sample rate, the number of idle delay bits ahead of each word, and the word width. The bit clock period is the largest whole number of master-clock cycles that still lets the delay bits plus the word fit in half a frame. The cycles left over are added to the final bit of each slot. When the serial output is wired straight back to the serial input, each receive register must hold the word that was sent on that channel.

Top module: `i2s_master_port`

## Requirements
- R1: `mclk` toggles on every `clk` cycle after reset, so it runs at half the `clk` rate.
- R2: `lrclk` stays in each level for HALF = (MCLK_HZ/FS_HZ)/2 master-clock cycles. Low marks the left slot and high marks the right slot.
- R3: `dout` changes only in the cycle where `bclk` falls. `din` is sampled in the cycle where `bclk` rises.
- R4: Every bit except the last in a slot lasts BP = floor(HALF/(DELAY_BITS+WORD_W)) master-clock cycles. During a bit, `bclk` is low for the first BP/2 master-clock cycles and high for the rest. `bclk` changes only where `mclk` falls.
- R5: The last bit of each slot lasts BP + (HALF − BP·(DELAY_BITS+WORD_W)) master-clock cycles.
- R6: Each `lrclk` transition happens in the same cycle as a falling edge of `bclk`, which is the first falling edge of the new slot.
- R7: Each slot first sends DELAY_BITS bits driven to 0, then the word, most significant bit first.
- R8: The received bits that follow the delay bits are shifted in MSB first. A channel's output register (`rx_left` when `lrclk` is low, `rx_right` when it is high) updates only at the rising `bclk` that captures the word's last bit. In loopback it equals the word that was sent.
- R9: The transmit word is taken from `tx_left` or `tx_right` in the cycle the slot starts. Changes to the inputs during the slot do not change the word being sent.
- R10: A synchronous active-high `rst` drives `mclk`, `lrclk`, `bclk`, `dout`, `rx_left` and `rx_right` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the master clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_left | input | WORD_W | Left-channel word to send |
| tx_right | input | WORD_W | Right-channel word to send |
| din | input | 1 | Serial receive data |
| rx_left | output | WORD_W | Last complete left word received |
| rx_right | output | WORD_W | Last complete right word received |
| mclk | output | 1 | Codec master clock |
| lrclk | output | 1 | Frame clock, 0 = left, 1 = right |
| bclk | output | 1 | Bit clock |
| dout | output | 1 | Serial transmit data |

## Verification
The bench runs two configurations. The first has one delay bit, a 16-bit word and a long stretched final bit. The second has no delay bit, a 24-bit word and no remainder. A design that ignored the remainder would put too few cycles in a slot or give the last bit the wrong length. A design that forgot to zero the delay bit or mishandled it would shift every decoded word by one place.

In the middle of every slot the bench changes the transmit inputs to junk. A design that samples the inputs late would then send a mixture of two words.

The directed words are all zeros, all ones, a lone MSB and a lone LSB. They catch bit-order and end-of-word mistakes, and they also catch a receive register that updates one bit too early.

// File: rtl/i2s_master_pkg.sv
package i2s_master_pkg;

  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;

  // master-clock cycles in one half frame
  function automatic int half_frame(input int mclk_hz, input int fs_hz);
    return (mclk_hz / fs_hz) / 2;
  endfunction

  // widest bit that still fits every bit of a slot in a half frame
  function automatic int bit_len(input int half, input int nbits);
    return half / nbits;
  endfunction

  // cycles added to the final bit of each slot
  function automatic int tail_len(input int half, input int nbits);
    return half - (half / nbits) * nbits;
  endfunction

endpackage

// File: rtl/i2s_mclk_gen.sv
module i2s_mclk_gen (
  input  logic clk,
  input  logic rst,
  output logic mclk,
  output logic ce
);
  always_ff @(posedge clk) begin
    if (rst) mclk <= 1'b0;
    else     mclk <= ~mclk;
  end

  // state advances on the edge where mclk falls
  assign ce = mclk;
endmodule

// File: rtl/i2s_slot_timer.sv
module i2s_slot_timer
  import i2s_master_pkg::*;
#(
  parameter int BIT_MCLK = 2,
  parameter int TAIL     = 0,
  parameter int NBITS    = 17,
  parameter int DELAY    = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  output logic lrclk,
  output logic bclk,
  output logic bit_start,
  output logic slot_start,
  output chan_e next_chan,
  output chan_e cur_chan,
  output logic tx_bit,
  output logic sample,
  output logic rx_bit,
  output logic rx_last
);
  localparam int LAST_LEN = BIT_MCLK + TAIL;
  localparam int CW       = $clog2(LAST_LEN + 1);
  localparam int IW       = $clog2(NBITS + 1);
  localparam int HI_AT    = BIT_MCLK / 2;

  logic [CW-1:0] bcnt_q, bcnt_n, end_cnt;
  logic [IW-1:0] bidx_q, bidx_n;
  chan_e         lr_q, lr_n;
  logic          bclk_q;
  logic          last, at_end;

  always_comb begin
    last    = (bidx_q == IW'(NBITS - 1));
    end_cnt = last ? CW'(LAST_LEN - 1) : CW'(BIT_MCLK - 1);
    at_end  = (bcnt_q == end_cnt);
    bcnt_n  = at_end ? '0 : bcnt_q + CW'(1);
    bidx_n  = bidx_q;
    lr_n    = lr_q;
    if (at_end) begin
      if (last) begin
        bidx_n = '0;
        lr_n   = (lr_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
      end else begin
        bidx_n = bidx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt_q <= '0;
      bidx_q <= '0;
      lr_q   <= CH_LEFT;
      bclk_q <= 1'b0;
    end else if (ce) begin
      bcnt_q <= bcnt_n;
      bidx_q <= bidx_n;
      lr_q   <= lr_n;
      bclk_q <= (bcnt_n >= CW'(HI_AT));
    end
  end

  assign lrclk      = lr_q;
  assign bclk       = bclk_q;
  assign bit_start  = ce && at_end;
  assign slot_start = ce && at_end && last;
  assign next_chan  = lr_n;
  assign cur_chan   = lr_q;
  assign sample     = ce && (bcnt_q == CW'(HI_AT - 1));
  assign rx_last    = last;

  if (DELAY == 0) begin : g_no_delay
    assign tx_bit = 1'b1;
    assign rx_bit = 1'b1;
  end else begin : g_delay
    assign tx_bit = (bidx_n >= IW'(DELAY));
    assign rx_bit = (bidx_q >= IW'(DELAY));
  end
endmodule

// File: rtl/i2s_tx_shift.sv
module i2s_tx_shift
  import i2s_master_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_start,
  input  logic         slot_start,
  input  chan_e        next_chan,
  input  logic         tx_bit,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  output logic         dout
);
  logic [W-1:0] sreg, pick;

  assign pick = (next_chan == CH_RIGHT) ? tx_right : tx_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      dout <= 1'b0;
    end else if (slot_start) begin
      if (tx_bit) begin
        dout <= pick[W-1];
        sreg <= pick << 1;
      end else begin
        dout <= 1'b0;
        sreg <= pick;
      end
    end else if (bit_start) begin
      if (tx_bit) begin
        dout <= sreg[W-1];
        sreg <= sreg << 1;
      end else begin
        dout <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2s_rx_shift.sv
module i2s_rx_shift
  import i2s_master_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample,
  input  logic         rx_bit,
  input  logic         rx_last,
  input  chan_e        cur_chan,
  input  logic         din,
  output logic [W-1:0] rx_left,
  output logic [W-1:0] rx_right
);
  logic [W-1:0] sreg, nxt;

  assign nxt = {sreg[W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '0;
      rx_left  <= '0;
      rx_right <= '0;
    end else if (sample && rx_bit) begin
      sreg <= nxt;
      if (rx_last) begin
        if (cur_chan == CH_RIGHT) rx_right <= nxt;
        else                      rx_left  <= nxt;
      end
    end
  end
endmodule

// File: rtl/i2s_master_port.sv
module i2s_master_port
  import i2s_master_pkg::*;
#(
  parameter int MCLK_HZ    = 12_000_000,
  parameter int FS_HZ      = 8000,
  parameter int DELAY_BITS = 1,
  parameter int WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  input  logic              din,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              mclk,
  output logic              lrclk,
  output logic              bclk,
  output logic              dout
);
  localparam int NBITS    = DELAY_BITS + WORD_W;
  localparam int HALF     = half_frame(MCLK_HZ, FS_HZ);
  localparam int BIT_MCLK = bit_len(HALF, NBITS);
  localparam int TAIL     = tail_len(HALF, NBITS);

  logic  ce, bit_start, slot_start, tx_bit, sample, rx_bit, rx_last;
  chan_e next_chan, cur_chan;

  i2s_mclk_gen u_mclk (
    .clk (clk), .rst (rst), .mclk (mclk), .ce (ce)
  );

  i2s_slot_timer #(
    .BIT_MCLK (BIT_MCLK), .TAIL (TAIL), .NBITS (NBITS), .DELAY (DELAY_BITS)
  ) u_timer (
    .clk (clk), .rst (rst), .ce (ce),
    .lrclk (lrclk), .bclk (bclk),
    .bit_start (bit_start), .slot_start (slot_start),
    .next_chan (next_chan), .cur_chan (cur_chan),
    .tx_bit (tx_bit), .sample (sample), .rx_bit (rx_bit), .rx_last (rx_last)
  );

  i2s_tx_shift #(.W (WORD_W)) u_tx (
    .clk (clk), .rst (rst),
    .bit_start (bit_start), .slot_start (slot_start),
    .next_chan (next_chan), .tx_bit (tx_bit),
    .tx_left (tx_left), .tx_right (tx_right), .dout (dout)
  );

  i2s_rx_shift #(.W (WORD_W)) u_rx (
    .clk (clk), .rst (rst),
    .sample (sample), .rx_bit (rx_bit), .rx_last (rx_last),
    .cur_chan (cur_chan), .din (din),
    .rx_left (rx_left), .rx_right (rx_right)
  );
endmodule

// File: rtl/i2s_master_port_chk.sv
module i2s_master_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         mclk,
  input logic         lrclk,
  input logic         bclk,
  input logic         dout,
  input logic [W-1:0] rx_left,
  input logic [W-1:0] rx_right
);
  assert_mclk_fall_R1: assert property (@(posedge clk) disable iff (rst)
    mclk |=> !mclk);
  assert_mclk_rise_R1: assert property (@(posedge clk) disable iff (rst)
    !mclk |=> mclk);
  assert_dout_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> $fell(bclk));
  assert_bclk_on_mclk_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(bclk) |-> $fell(mclk));
  assert_lr_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrclk) |-> $fell(bclk));
  assert_rx_left_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_left) |-> ($rose(bclk) && !lrclk));
  assert_rx_right_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_right) |-> ($rose(bclk) && lrclk));
endmodule

bind i2s_master_port i2s_master_port_chk #(.W (WORD_W)) u_chk (
  .clk (clk), .rst (rst), .mclk (mclk), .lrclk (lrclk), .bclk (bclk),
  .dout (dout), .rx_left (rx_left), .rx_right (rx_right)
);

// File: tb/i2s_master_port_tb_top.sv
`timescale 1ns/1ps

module i2s_link_mon #(
  parameter int W        = 16,
  parameter int DELAY    = 1,
  parameter int NBITS    = 17,
  parameter int HALF_SYS = 96,
  parameter int BIT_SYS  = 4,
  parameter int LAST_SYS = 32,
  parameter int HI_SYS   = 2
) (
  input  logic         clk,
  input  logic         en,
  input  logic         mclk,
  input  logic         lrclk,
  input  logic         bclk,
  input  logic         dout,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  input  logic [W-1:0] rx_left,
  input  logic [W-1:0] rx_right,
  output int           nchk,
  output int           nbad
);
  logic         p_mclk, p_lr, p_bclk, armed, mclk_err;
  logic [W-1:0] exp_w, dec;
  int           cyc, since_fall, nfall, ridx;

  task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s (W=%0d): actual=%0h expected=%0h", tag, W, act, expv);
    end
  endtask

  initial begin
    nchk = 0; nbad = 0; armed = 0; mclk_err = 0;
    p_mclk = 0; p_lr = 0; p_bclk = 0;
    cyc = 0; since_fall = 0; nfall = 0; ridx = 0; dec = '0; exp_w = '0;
  end

  always @(negedge clk) begin
    if (en) begin
      cyc++;
      since_fall++;
      if (mclk == p_mclk) mclk_err = 1;
      if (!p_bclk && bclk && armed) begin
        chk(since_fall == HI_SYS, "R4 bclk high point", since_fall, HI_SYS);
        if (ridx < DELAY) chk(dout == 1'b0, "R7 delay bit zero", dout, 0);
        else dec = {dec[W-2:0], dout};
        ridx++;
      end
      if (lrclk != p_lr) begin
        if (armed) begin
          chk(p_bclk && !bclk, "R6 lrclk on bclk fall", bclk, 0);
          chk(cyc == HALF_SYS, "R2 half frame length", cyc, HALF_SYS);
          chk(nfall == NBITS - 1, "R4 bits per slot", nfall + 1, NBITS);
          chk(since_fall == LAST_SYS, "R5 stretched last bit", since_fall, LAST_SYS);
          chk(dec == exp_w, "R7 R9 serial word", dec, exp_w);
          chk((p_lr ? rx_right : rx_left) == exp_w, "R8 loopback word", p_lr ? rx_right : rx_left, exp_w);
          chk(!mclk_err, "R1 mclk toggles", mclk_err, 0);
        end
        armed = 1;
        exp_w = lrclk ? tx_right : tx_left;
        cyc = 0; since_fall = 0; nfall = 0; ridx = 0; dec = '0; mclk_err = 0;
      end else if (p_bclk && !bclk) begin
        if (armed) chk(since_fall == BIT_SYS, "R4 bit period", since_fall, BIT_SYS);
        nfall++;
        since_fall = 0;
      end
      p_mclk = mclk; p_lr = lrclk; p_bclk = bclk;
    end
  end
endmodule

module i2s_master_port_tb_top;
  localparam int W1 = 16;
  localparam int W2 = 24;
  localparam int NSLOTS = 150;
  localparam int LIMIT  = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #2.5 clk = ~clk;

  logic [W1-1:0] txl1, txr1, rxl1, rxr1;
  logic [W2-1:0] txl2, txr2, rxl2, rxr2;
  logic mclk1, lr1, bclk1, dout1, mclk2, lr2, bclk2, dout2;
  int tb_chk, tb_bad, c1, b1, c2, b2;
  logic done;

  i2s_master_port #(.MCLK_HZ(1_536_000), .FS_HZ(16000), .DELAY_BITS(1), .WORD_W(W1)) dut_i (
    .clk(clk), .rst(rst), .tx_left(txl1), .tx_right(txr1), .din(dout1),
    .rx_left(rxl1), .rx_right(rxr1), .mclk(mclk1), .lrclk(lr1), .bclk(bclk1), .dout(dout1));

  i2s_master_port #(.MCLK_HZ(3_072_000), .FS_HZ(32000), .DELAY_BITS(0), .WORD_W(W2)) dut2_i (
    .clk(clk), .rst(rst), .tx_left(txl2), .tx_right(txr2), .din(dout2),
    .rx_left(rxl2), .rx_right(rxr2), .mclk(mclk2), .lrclk(lr2), .bclk(bclk2), .dout(dout2));

  i2s_link_mon #(.W(W1), .DELAY(1), .NBITS(17), .HALF_SYS(96), .BIT_SYS(4), .LAST_SYS(32), .HI_SYS(2)) mon1 (
    .clk(clk), .en(en), .mclk(mclk1), .lrclk(lr1), .bclk(bclk1), .dout(dout1),
    .tx_left(txl1), .tx_right(txr1), .rx_left(rxl1), .rx_right(rxr1), .nchk(c1), .nbad(b1));

  i2s_link_mon #(.W(W2), .DELAY(0), .NBITS(24), .HALF_SYS(96), .BIT_SYS(4), .LAST_SYS(4), .HI_SYS(2)) mon2 (
    .clk(clk), .en(en), .mclk(mclk2), .lrclk(lr2), .bclk(bclk2), .dout(dout2),
    .tx_left(txl2), .tx_right(txr2), .rx_left(rxl2), .rx_right(rxr2), .nchk(c2), .nbad(b2));

  function automatic logic [W2-1:0] pick_word(input int s, input int w);
    logic [W2-1:0] v;
    case (s)
      0: v = '0;
      1: v = '1;
      2: v = W2'(1) << (w - 1);
      3: v = W2'(1);
      default: v = W2'($urandom);
    endcase
    return v;
  endfunction

  task automatic tb_check(input logic ok, input string tag, input longint act, input longint expv);
    tb_chk++;
    if (!ok) begin
      tb_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", tb_chk + c1 + c2, tb_bad + b1 + b2);
    $finish;
  endtask

  initial begin
    logic lr_seen;
    tb_chk = 0; tb_bad = 0; done = 0;
    void'($urandom(32'd4711));
    txl1 = 16'h1234; txr1 = 16'hABCD; txl2 = 24'h123456; txr2 = 24'hFEDCBA;
    repeat (6) @(negedge clk);
    // R10: reset state at the ports
    tb_check({mclk1, lr1, bclk1, dout1} == 4'b0, "R10 reset clocks dut1", {mclk1, lr1, bclk1, dout1}, 0);
    tb_check({mclk2, lr2, bclk2, dout2} == 4'b0, "R10 reset clocks dut2", {mclk2, lr2, bclk2, dout2}, 0);
    tb_check(rxl1 == '0 && rxr1 == '0, "R10 reset rx dut1", {rxl1, rxr1}, 0);
    tb_check(rxl2 == '0 && rxr2 == '0, "R10 reset rx dut2", {rxl2, rxr2}, 0);
    #1 rst = 1'b0; en = 1'b1;
    lr_seen = 1'b0;
    for (int s = 0; s < NSLOTS; s++) begin
      do @(negedge clk); while (lr1 == lr_seen);
      lr_seen = lr1;
      repeat (30) @(negedge clk);
      #1;
      // R9: junk mid-slot must not reach the serial word
      txl1 = W1'($urandom); txr1 = W1'($urandom);
      txl2 = W2'($urandom); txr2 = W2'($urandom);
      repeat (40) @(negedge clk);
      #1;
      txl1 = W1'(pick_word(s, W1)); txr1 = W1'(pick_word(s + 1, W1));
      txl2 = pick_word(s, W2);      txr2 = pick_word(s + 1, W2);
    end
    repeat (200) @(negedge clk);
    // R10 again: synchronous reset mid-run clears outputs
    #1 rst = 1'b1; en = 1'b0;
    repeat (4) @(negedge clk);
    tb_check({mclk1, lr1, bclk1, dout1} == 4'b0, "R10 mid-run reset dut1", {mclk1, lr1, bclk1, dout1}, 0);
    tb_check(rxl2 == '0 && rxr2 == '0 && dout2 == 1'b0, "R10 mid-run reset dut2", {rxl2, rxr2}, 0);
    done = 1;
    report();
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      tb_chk++;
      tb_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", LIMIT, 0);
      report();
    end
  end
endmodule